// File: doc/BRIEF.md
# Two-Wire Serial Slave with Byte Register File

This block is a slave on a two-wire serial bus (I2C-compatible) with a small byte-wide register file behind it. SCL and SDA are brought into the system clock domain through synchronizers. The block watches them for START and STOP conditions. The synchronized lines also give the SCL rising and falling edges that drive the byte protocol. The block never drives SDA high. It only asserts an open-drain enable, which pulls the line low.

The device address is seven bits. Its upper five bits are fixed at binary 11000, and its lowest two bits come from two strap pins. In a write transaction the first byte after the address is a register pointer. Every later byte is stored at the pointer, and the pointer then steps forward. To read, the master first writes the pointer. It then issues a repeated START with the read bit set. The block sends successive registers until the master answers with a NACK. The whole register file is also shown on a parallel output so that its contents can be checked.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset the SDA pull-down enable is 0 and all 16 registers read 0x00 on the parallel output (register n occupies bits 8n+7..8n).
- R2: After a START, an address byte whose upper seven bits equal 11000 followed by addr_sel_i[1] then addr_sel_i[0] is acknowledged. The block pulls SDA low (enable 1) while SCL is high in the ninth clock. The lowest bit of the byte is the direction: 0 means write and 1 means read.
- R3: An address byte that does not match is not acknowledged (SDA stays released). Every later byte is then ignored, and no register changes, until the next START or STOP.
- R4: In a write transaction the byte after the address loads the pointer and is acknowledged. Each later byte is received MSB first and stored at the pointer. Each such byte is acknowledged and then advances the pointer by one. The transaction ends only at STOP. Writing 0x0E, 0xD8 and 0xE1 from pointer 0 leaves registers 0, 1 and 2 holding those values.
- R5: After a pointer write, a repeated START with the matching address and the read bit set is acknowledged. The block then sends the register at the pointer, MSB first.
- R6: During a read, a master ACK (SDA low in the ninth clock) makes the block send the next register. After a master NACK the block keeps SDA released until the next START.
- R7: The pointer wraps from register 15 to register 0 for both writes and reads.
- R8: A write to a pointer of 16 or more is acknowledged but changes no register. A read from such a pointer returns 0x00.
- R9: The block changes its SDA enable only while SCL is low.
- R10: A START or STOP in any state, including the middle of a byte, resets the bit count. A transaction that begins after it works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| addr_sel_i | input | 2 | Strap pins giving the two low address bits |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| regs_o | output | 128 | Register file contents, register n at bits 8n+7..8n |

## Verification
The assertions assume a master that is well formed. It changes SDA only while SCL is low, except when it makes a START or STOP. Each SCL phase lasts many system clocks, so that the synchronized edges are seen in order, and a START is never made while the slave pulls SDA low. The bench master holds each SCL phase for twenty system clocks. It changes its data in the low phase and samples in the middle of the high phase. It issues START and STOP only from a released bus.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } rf_state_e;
endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_rf_cond.sv
module i2c_rf_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign start_o = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o  = scl_s & scl_d & ~sda_d & sda_s;
  assign rise_o  = scl_s & ~scl_d;
  assign fall_o  = ~scl_s & scl_d;
endmodule

// File: rtl/i2c_rf_regs.sv
module i2c_rf_regs #(
  parameter int NREG = 16,
  parameter int DW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [7:0]         waddr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [7:0]         raddr_i,
  output logic [DW-1:0]      rdata_o,
  output logic [NREG*DW-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] r_q;
    logic          hit;
    assign hit = we_i && (waddr_i == 8'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   r_q <= '0;
      else if (hit) r_q <= wdata_i;
    end
    assign regs_o[g*DW +: DW] = r_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++)
      if (raddr_i == 8'(i)) rdata_o = regs_o[i*DW +: DW];
  end
endmodule

// File: rtl/i2c_rf_fsm.sv
module i2c_rf_fsm
  import i2c_rf_pkg::*;
#(
  parameter int         NREG    = 16,
  parameter logic [4:0] DEV_HI  = 5'b11000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic [1:0] addr_sel_i,
  input  logic [7:0] rdata_i,
  output logic       we_o,
  output logic [7:0] ptr_o,
  output logic [7:0] wdata_o,
  output logic       sda_oe_o,
  output rf_state_e  state_o
);
  localparam logic [7:0] LAST = 8'(NREG - 1);

  rf_state_e  st_q, st_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] rx_q, rx_d, tx_q, tx_d, ptr_q, ptr_d, ptr_inc;
  logic       oe_q, oe_d, mack_q, mack_d, active;

  assign ptr_inc = (ptr_q == LAST) ? 8'd0 : ptr_q + 8'd1;
  assign active  = (st_q != ST_IDLE) && (st_q != ST_IGNORE);

  always_comb begin
    st_d = st_q; bit_d = bit_q; rx_d = rx_q; tx_d = tx_q;
    ptr_d = ptr_q; oe_d = oe_q; mack_d = mack_q; we_o = 1'b0;
    if (start_i) begin
      st_d = ST_ADDR; bit_d = '0; oe_d = 1'b0;
    end else if (stop_i) begin
      st_d = ST_IDLE; bit_d = '0; oe_d = 1'b0;
    end else if (rise_i && active) begin
      if (bit_q < 4'd8) begin
        rx_d  = {rx_q[6:0], sda_s};
        tx_d  = {tx_q[6:0], 1'b0};
        bit_d = bit_q + 4'd1;
      end else if (bit_q == 4'd8) begin
        bit_d = 4'd9;
        if (st_q == ST_RDATA) mack_d = ~sda_s;
      end
    end else if (fall_i && active) begin
      if (bit_q == 4'd8) begin
        unique case (st_q)
          ST_ADDR: begin
            if (rx_q[7:1] == {DEV_HI, addr_sel_i}) begin
              oe_d = 1'b1;
              st_d = rx_q[0] ? ST_RDATA : ST_PTR;
            end else begin
              st_d = ST_IGNORE;
            end
          end
          ST_PTR:   begin ptr_d = rx_q; oe_d = 1'b1; st_d = ST_WDATA; end
          ST_WDATA: begin we_o = 1'b1; ptr_d = ptr_inc; oe_d = 1'b1; end
          default:  oe_d = 1'b0;
        endcase
      end else if (bit_q == 4'd9) begin
        bit_d = '0;
        oe_d  = 1'b0;
        if (st_q == ST_RDATA) begin
          if (mack_q) begin
            tx_d  = rdata_i;
            oe_d  = ~rdata_i[7];
            ptr_d = ptr_inc;
          end else begin
            st_d = ST_IGNORE;
          end
        end
      end else if (bit_q != 4'd0 && st_q == ST_RDATA) begin
        oe_d = ~tx_q[7];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; bit_q <= '0; rx_q <= '0; tx_q <= '0;
      ptr_q <= '0; oe_q <= 1'b0; mack_q <= 1'b0;
    end else begin
      st_q <= st_d; bit_q <= bit_d; rx_q <= rx_d; tx_q <= tx_d;
      ptr_q <= ptr_d; oe_q <= oe_d; mack_q <= mack_d;
    end
  end

  assign ptr_o    = ptr_q;
  assign wdata_o  = rx_q;
  assign sda_oe_o = oe_q;
  assign state_o  = st_q;
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
  import i2c_rf_pkg::*;
#(
  parameter int         NREG        = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] DEV_HI      = 5'b11000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic [1:0]      addr_sel_i,
  output logic            sda_oe_o,
  output logic [NREG*8-1:0] regs_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int;
  logic       scl_s, sda_s, start_w, stop_w, rise_w, fall_w, we_w;
  logic [7:0] ptr_w, wdata_w, rdata_w;
  rf_state_e  state_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int = rst_sync_q[1];

  i2c_rf_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_int), .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  i2c_rf_cond i_cond (
    .clk(clk), .rst_n(rst_int), .scl_s(scl_s), .sda_s(sda_s),
    .start_o(start_w), .stop_o(stop_w), .rise_o(rise_w), .fall_o(fall_w)
  );

  i2c_rf_fsm #(.NREG(NREG), .DEV_HI(DEV_HI)) i_fsm (
    .clk(clk), .rst_n(rst_int), .sda_s(sda_s), .start_i(start_w),
    .stop_i(stop_w), .rise_i(rise_w), .fall_i(fall_w),
    .addr_sel_i(addr_sel_i), .rdata_i(rdata_w), .we_o(we_w),
    .ptr_o(ptr_w), .wdata_o(wdata_w), .sda_oe_o(sda_oe_o), .state_o(state_w)
  );

  i2c_rf_regs #(.NREG(NREG), .DW(8)) i_regs (
    .clk(clk), .rst_n(rst_int), .we_i(we_w), .waddr_i(ptr_w),
    .wdata_i(wdata_w), .raddr_i(ptr_w), .rdata_o(rdata_w), .regs_o(regs_o)
  );
endmodule

// File: rtl/i2c_rf_chk.sv
module i2c_rf_chk
  import i2c_rf_pkg::*;
#(
  parameter int NREG = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start,
  input logic              stop,
  input logic              scl_fall,
  input rf_state_e         state,
  input logic              sda_oe,
  input logic [NREG*8-1:0] regs
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s)); // R9
  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!sda_oe && state == ST_ADDR)); // R10
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!sda_oe && state == ST_IDLE)); // R10
  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_oe); // R3
  AST_REGS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs) |-> ($past(scl_fall) && $past(state) == ST_WDATA)); // R4
endmodule

bind i2c_regfile_slave i2c_rf_chk #(.NREG(NREG)) i_chk (
  .clk(clk), .rst_n(rst_int), .scl_s(scl_s), .start(start_w), .stop(stop_w),
  .scl_fall(fall_w), .state(state_w), .sda_oe(sda_oe_o), .regs(regs_o)
);

// File: tb/test_i2c_regfile_slave.sv
`timescale 1ns/1ps
module test_i2c_regfile_slave;
  localparam int NREG = 16;
  localparam int Q    = 20;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [1:0] sel = 2'b10;
  logic sda_oe, sda_line;
  logic [NREG*8-1:0] regs;
  logic [7:0] model [NREG];
  int checks = 0, fails = 0, r9_viol = 0;
  bit done = 0;

  typedef struct { logic [7:0] v; string tag; } item_t;
  item_t exp_q[$], act_q[$];

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_regfile_slave i_i2c_regfile_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_sel_i(sel), .sda_oe_o(sda_oe), .regs_o(regs)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n); repeat (n) @(posedge clk); #1; endtask

  task automatic expect_item(input logic [7:0] v, input string tag);
    exp_q.push_back('{v, tag});
  endtask

  task automatic bitx(input logic b, output logic r);
    sda_m = b; clks(Q); scl = 1'b1; clks(Q/2); r = sda_line; clks(Q/2); scl = 1'b0;
  endtask

  task automatic start_c;
    sda_m = 1'b1; clks(Q); scl = 1'b1; clks(Q); sda_m = 1'b0; clks(Q); scl = 1'b0; clks(Q);
  endtask

  task automatic stop_c;
    sda_m = 1'b0; clks(Q); scl = 1'b1; clks(Q); sda_m = 1'b1; clks(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, input string tag, input logic exp_ack);
    logic r;
    for (int i = 7; i >= 0; i--) bitx(b[i], r);
    bitx(1'b1, r);
    expect_item({7'd0, ~exp_ack}, tag);
    act_q.push_back('{{7'd0, r}, tag});
  endtask

  task automatic rbyte(input logic mack, input logic [7:0] expv, input string tag);
    logic r; logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin bitx(1'b1, r); v[i] = r; end
    bitx(~mack, r);
    expect_item(expv, tag);
    act_q.push_back('{v, tag});
  endtask

  function automatic logic [7:0] dev(input logic [1:0] s, input logic rw);
    return {5'b11000, s, rw};
  endfunction

  function automatic logic [127:0] flat();
    logic [127:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        item_t a, e;
        a = act_q.pop_front(); e = exp_q.pop_front();
        chk(e.tag, {120'd0, a.v}, {120'd0, e.v});
      end
    end
  end

  // R9 observer: enable must not move while SCL is high
  logic oe_prev;
  always @(negedge clk) begin
    if (rst_n && scl && oe_prev !== sda_oe) r9_viol++;
    oe_prev = sda_oe;
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    scl = 1'b0; sda_m = 1'b1;
    clks(5); scl = 1'b1; rst_n = 1'b1; clks(10);
    chk("R1 oe after reset", {127'd0, sda_oe}, 128'd0);
    chk("R1 regs after reset", regs, 128'd0);
    scl = 1'b1;

    // R2 R4 write example
    start_c;
    wbyte(dev(sel, 1'b0), "R2 address ack", 1'b1);
    wbyte(8'h00, "R4 pointer ack", 1'b1);
    wbyte(8'h0E, "R4 data0 ack", 1'b1);
    wbyte(8'hD8, "R4 data1 ack", 1'b1);
    wbyte(8'hE1, "R4 data2 ack", 1'b1);
    stop_c;
    model[0] = 8'h0E; model[1] = 8'hD8; model[2] = 8'hE1;
    chk("R4 regs after write", regs, flat());

    // R5 R6 read via repeated start
    start_c;
    wbyte(dev(sel, 1'b0), "R5 address ack", 1'b1);
    wbyte(8'h00, "R5 pointer ack", 1'b1);
    start_c;
    wbyte(dev(sel, 1'b1), "R5 read address ack", 1'b1);
    rbyte(1'b1, 8'h0E, "R5 read reg0");
    rbyte(1'b0, 8'hD8, "R6 read reg1 after ack");
    clks(Q);
    chk("R6 released after nack", {127'd0, sda_oe}, 128'd0);
    stop_c;

    // R7 wrap on write and read
    start_c;
    wbyte(dev(sel, 1'b0), "R7 address ack", 1'b1);
    wbyte(8'h0F, "R7 pointer ack", 1'b1);
    wbyte(8'hA5, "R7 data15 ack", 1'b1);
    wbyte(8'h3C, "R7 data wrap ack", 1'b1);
    start_c;
    wbyte(dev(sel, 1'b0), "R7 address2 ack", 1'b1);
    wbyte(8'h0F, "R7 pointer2 ack", 1'b1);
    start_c;
    wbyte(dev(sel, 1'b1), "R7 read address ack", 1'b1);
    rbyte(1'b1, 8'hA5, "R7 read reg15");
    rbyte(1'b1, 8'h3C, "R7 read wrapped reg0");
    rbyte(1'b0, 8'hD8, "R7 read reg1");
    stop_c;
    model[15] = 8'hA5; model[0] = 8'h3C;
    chk("R7 regs after wrap", regs, flat());

    // R8 out of range
    start_c;
    wbyte(dev(sel, 1'b0), "R8 address ack", 1'b1);
    wbyte(8'h20, "R8 pointer ack", 1'b1);
    wbyte(8'h77, "R8 discarded data ack", 1'b1);
    stop_c;
    chk("R8 regs unchanged", regs, flat());
    start_c;
    wbyte(dev(sel, 1'b0), "R8 address2 ack", 1'b1);
    wbyte(8'h40, "R8 pointer2 ack", 1'b1);
    start_c;
    wbyte(dev(sel, 1'b1), "R8 read address ack", 1'b1);
    rbyte(1'b0, 8'h00, "R8 read out of range");
    stop_c;

    // R3 mismatched address, both pin and fixed part
    start_c;
    wbyte(dev(~sel, 1'b0), "R3 pin mismatch nack", 1'b0);
    wbyte(8'h01, "R3 ignored pointer", 1'b0);
    wbyte(8'h55, "R3 ignored data", 1'b0);
    stop_c;
    start_c;
    wbyte({5'b11001, sel, 1'b0}, "R3 fixed mismatch nack", 1'b0);
    wbyte(8'h02, "R3 ignored pointer2", 1'b0);
    wbyte(8'h66, "R3 ignored data2", 1'b0);
    stop_c;
    chk("R3 regs unchanged", regs, flat());

    // R10 START in the middle of a byte
    begin
      logic r;
      start_c;
      for (int i = 0; i < 4; i++) bitx(i[0], r);
      start_c;
      wbyte(dev(sel, 1'b0), "R10 address ack after abort", 1'b1);
      wbyte(8'h05, "R10 pointer ack", 1'b1);
      wbyte(8'h9B, "R10 data ack", 1'b1);
      stop_c;
      model[5] = 8'h9B;
      chk("R10 regs after restart", regs, flat());
    end

    // R2 with other strap value
    sel = 2'b01; clks(10);
    start_c;
    wbyte(dev(2'b01, 1'b0), "R2 address ack strap 01", 1'b1);
    wbyte(8'h07, "R2 pointer ack strap 01", 1'b1);
    wbyte(8'hC3, "R2 data ack strap 01", 1'b1);
    stop_c;
    model[7] = 8'hC3;
    chk("R2 regs strap 01", regs, flat());

    clks(10);
    chk("R9 no enable change while SCL high", r9_viol, 0);
    chk("scoreboard drained", exp_q.size(), act_q.size());
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule